// File: doc/BRIEF.md
# Channel LLR Scaling Quantizer

This block turns received BPSK soft samples into the fixed-point channel log-likelihood ratios that seed the soft-output memory of a layered LDPC decoder. Each sample is first limited to a symmetric clip point. It is then multiplied by a scale factor and rounded to a symmetric signed integer of a few bits. The clip point and the scale factor form a pair, one pair per code rate. The scale factor is chosen so that the clip point lands exactly on the largest output code. The saturated codes then occur about as often as the interior ones, and the block needs no noise-variance estimate.

A small constant table holds the pairs and is indexed by the code-rate select input. Each pair is fixed at build time for a design SNR. Only the clip points are given as parameters; the scale factors are derived from them at elaboration. One valid strobe accompanies each sample. The result appears one cycle later in two forms: as the narrow LLR, and sign-extended to the soft-output word width so that it can be written straight in as an initial soft value.

Top module: `llr_quantizer`

## Requirements
- R1: While rst_ni is low, and after it rises until the first accepted sample, valid_o is 0, llr_o is 0 and so_o is 0.
- R2: A sample taken with valid_i = 1 at a rising edge produces valid_o = 1 during the following cycle, computed from the sample_i and rate_i of that edge. valid_o is 0 in the cycle after an edge where valid_i = 0. Back-to-back samples with different rate_i values are each processed with their own rate.
- R3: sample_i is signed Q3.8 (value = sample_i / 256). Its magnitude is clipped to the selected threshold before scaling. llr_o never leaves the range -(2^(LLR_W-1)-1) to +(2^(LLR_W-1)-1), which is ±15 for LLR_W = 5, so the code -16 never appears.
- R4: Rate code k (0..NUM_RATES-1) selects threshold T_k, taken from CLIP_TABLE bits [k*SAMPLE_W +: SAMPLE_W] in Q3.8. The scale is S_k = round(15*2^16 / T_k) in unsigned Q4.8. By default T = 384, 512, 632, 768 (1.5, 2.0, 2.47, 3.0) and S = 2560, 1920, 1555, 1280. The output magnitude is floor((min(|y|,T_k)*S_k + 2^15) / 2^16), limited to 15.
- R5: Rounding is to nearest with ties away from zero: an exact product of +2.5 gives +3 and -2.5 gives -3.
- R6: The mapping is odd-symmetric: the output for -y is the negation of the output for y, including the full-scale input -8.0 (sample 0x800).
- R7: For every rate, a sample equal to +T_k gives +15 and -T_k gives -15, and any magnitude above T_k gives ±15.
- R8: A sample presented with valid_i = 0 is ignored: llr_o and so_o keep their previous values.
- R9: so_o is llr_o sign-extended to SO_W bits (6 by default), so -15 appears as 6'b110001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| sample_i | input | SAMPLE_W (12) | Soft sample, signed Q3.8 |
| rate_i | input | RATE_W (2) | Code-rate select, indexes the clip/scale table |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| llr_o | output | LLR_W (5) | Saturated channel LLR, symmetric two's complement |
| so_o | output | SO_W (6) | llr_o sign-extended to the soft-output width |

## Verification
The bench uses the default build: a 12-bit Q3.8 sample, a Q4.8 scale, a 5-bit LLR, a 6-bit soft-output word and four rates clipping at 1.5, 2.0, 2.47 and 3.0. The clip points 1.5, 2.0 and 3.0 give exact scale factors of 10, 7.5 and 5. Exact half-integer products are therefore reachable, and the tie rule can be checked in both signs. The 2.47 rate has an inexact scale, which tests whether the clip point still lands on code 15 after rounding. The 12-bit sample width puts the asymmetric input -8.0 inside the stimulus, so the negation overflow case is covered along with a strided sweep of the whole input range at every rate.

// File: rtl/llrq_pkg.sv
`timescale 1ns/1ps
package llrq_pkg;

  // scale in Q(frac) such that thr * scale lands on llr_max, rounded to nearest
  function automatic int calc_scale(int thr, int llr_max, int frac);
    int num;
    num = llr_max << (2 * frac);
    return (num + thr / 2) / thr;
  endfunction

  function automatic int rate_bits(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/llrq_rate_table.sv
`timescale 1ns/1ps
module llrq_rate_table #(
  parameter int SAMPLE_W    = 12,
  parameter int SAMPLE_FRAC = 8,
  parameter int SCALE_W     = 12,
  parameter int SCALE_FRAC  = 8,
  parameter int LLR_W       = 5,
  parameter int NUM_RATES   = 4,
  parameter logic [NUM_RATES*SAMPLE_W-1:0] CLIP_TABLE = {12'd768, 12'd632, 12'd512, 12'd384},
  localparam int RATE_W     = llrq_pkg::rate_bits(NUM_RATES)
) (
  input  logic [RATE_W-1:0]   rate_i,
  output logic [SAMPLE_W-1:0] thr_o,
  output logic [SCALE_W-1:0]  scale_o
);
  localparam int LLR_MAX = (1 << (LLR_W - 1)) - 1;
  localparam int SHIFT   = SAMPLE_FRAC + SCALE_FRAC;

  logic [SAMPLE_W-1:0] thr_tab [NUM_RATES];
  logic [SCALE_W-1:0]  scl_tab [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
    localparam logic [SAMPLE_W-1:0] THR = CLIP_TABLE[g*SAMPLE_W +: SAMPLE_W];
    localparam int SCL = llrq_pkg::calc_scale(int'(THR), LLR_MAX, SAMPLE_FRAC);
    assign thr_tab[g] = THR;
    assign scl_tab[g] = SCALE_W'(SCL);
  end

  assign thr_o   = thr_tab[rate_i];
  assign scale_o = scl_tab[rate_i];

  // R7: selected pair maps the clip point onto the top code
  always_comb begin
    if (!$isunknown(rate_i)) begin
      a_r7_full_scale: assert (((int'(thr_o) * int'(scale_o) + (1 << (SHIFT - 1))) >>> SHIFT) == LLR_MAX);
    end
  end

endmodule

// File: rtl/llrq_clip_scale.sv
`timescale 1ns/1ps
module llrq_clip_scale #(
  parameter int SAMPLE_W    = 12,
  parameter int SAMPLE_FRAC = 8,
  parameter int SCALE_W     = 12,
  parameter int SCALE_FRAC  = 8,
  parameter int LLR_W       = 5
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thr_i,
  input  logic [SCALE_W-1:0]  scale_i,
  output logic [LLR_W-1:0]    llr_o
);
  localparam int SHIFT   = SAMPLE_FRAC + SCALE_FRAC;
  localparam int PROD_W  = SAMPLE_W + SCALE_W;
  localparam int LLR_MAX = (1 << (LLR_W - 1)) - 1;
  localparam logic [PROD_W:0] HALF = (PROD_W + 1)'(1) << (SHIFT - 1);

  logic                neg;
  logic [SAMPLE_W-1:0] mag, clip;
  logic [PROD_W-1:0]   prod;
  logic [PROD_W:0]     rnd, rnd_sh;
  logic [LLR_W-1:0]    sat_mag;

  always_comb begin
    neg  = sample_i[SAMPLE_W-1];
    // unsigned view holds 2^(SAMPLE_W-1) for the most negative input
    mag  = neg ? (~sample_i + SAMPLE_W'(1)) : sample_i;
    clip = (mag > thr_i) ? thr_i : mag;
    prod = PROD_W'(clip) * PROD_W'(scale_i);
    // rounding on magnitude gives ties away from zero
    rnd    = {1'b0, prod} + HALF;
    rnd_sh = rnd >> SHIFT;
    sat_mag = (rnd_sh > (PROD_W + 1)'(LLR_MAX)) ? LLR_W'(LLR_MAX) : rnd_sh[LLR_W-1:0];
    llr_o   = neg ? (~sat_mag + LLR_W'(1)) : sat_mag;
  end

  // R6: nonzero result carries the sample's sign
  always_comb begin
    if (!$isunknown(sample_i) && !$isunknown(thr_i) && llr_o != '0) begin
      a_r6_sign_follows: assert (llr_o[LLR_W-1] == sample_i[SAMPLE_W-1]);
    end
  end

endmodule

// File: rtl/llr_quantizer.sv
`timescale 1ns/1ps
module llr_quantizer #(
  parameter int SAMPLE_W    = 12,
  parameter int SAMPLE_FRAC = 8,
  parameter int SCALE_W     = 12,
  parameter int SCALE_FRAC  = 8,
  parameter int LLR_W       = 5,
  parameter int SO_W        = 6,
  parameter int NUM_RATES   = 4,
  parameter logic [NUM_RATES*SAMPLE_W-1:0] CLIP_TABLE = {12'd768, 12'd632, 12'd512, 12'd384},
  localparam int RATE_W     = llrq_pkg::rate_bits(NUM_RATES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [RATE_W-1:0]   rate_i,
  output logic                valid_o,
  output logic [LLR_W-1:0]    llr_o,
  output logic [SO_W-1:0]     so_o
);
  logic [SAMPLE_W-1:0] thr;
  logic [SCALE_W-1:0]  scale;
  logic [LLR_W-1:0]    llr_d;

  llrq_rate_table #(
    .SAMPLE_W(SAMPLE_W), .SAMPLE_FRAC(SAMPLE_FRAC), .SCALE_W(SCALE_W),
    .SCALE_FRAC(SCALE_FRAC), .LLR_W(LLR_W), .NUM_RATES(NUM_RATES),
    .CLIP_TABLE(CLIP_TABLE)
  ) u_table (
    .rate_i (rate_i),
    .thr_o  (thr),
    .scale_o(scale)
  );

  llrq_clip_scale #(
    .SAMPLE_W(SAMPLE_W), .SAMPLE_FRAC(SAMPLE_FRAC), .SCALE_W(SCALE_W),
    .SCALE_FRAC(SCALE_FRAC), .LLR_W(LLR_W)
  ) u_clip (
    .sample_i(sample_i),
    .thr_i   (thr),
    .scale_i (scale),
    .llr_o   (llr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      llr_o   <= '0;
      so_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        llr_o <= llr_d;
        so_o  <= {{(SO_W - LLR_W){llr_d[LLR_W-1]}}, llr_d};
      end
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r8_hold_llr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(llr_o) && $stable(so_o)));
  a_r3_no_min_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    llr_o != {1'b1, {(LLR_W-1){1'b0}}});
  a_r9_so_extends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $signed(so_o) == SO_W'($signed(llr_o)));

endmodule

// File: tb/llr_quantizer_test.sv
`timescale 1ns/1ps
module llr_quantizer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic [1:0]  rate_i = '0;
  logic        valid_o;
  logic [4:0]  llr_o;
  logic [5:0]  so_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  llr_quantizer uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sample_i(sample_i),
    .rate_i(rate_i), .valid_o(valid_o), .llr_o(llr_o), .so_o(so_o)
  );

  // thresholds and scales from the requirement table
  function automatic int exp_llr(int rate, int y);
    int thr, scl, m, c, q;
    case (rate)
      0: begin thr = 384; scl = 2560; end
      1: begin thr = 512; scl = 1920; end
      2: begin thr = 632; scl = 1555; end
      default: begin thr = 768; scl = 1280; end
    endcase
    m = (y < 0) ? -y : y;
    c = (m > thr) ? thr : m;
    q = (c * scl + 32768) / 65536;
    if (q > 15) q = 15;
    return (y < 0) ? -q : q;
  endfunction

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // drive one sample, check llr and so one cycle later
  task automatic apply(string req, int rate, int y);
    int e;
    @(negedge clk);
    valid_i = 1'b1; rate_i = 2'(rate); sample_i = 12'(y);
    @(negedge clk);
    valid_i = 1'b0;
    e = exp_llr(rate, y);
    chk({req, " valid"}, int'(valid_o), 1);
    chk({req, " llr"}, int'($signed(llr_o)), e);
    chk({req, " R9 so"}, int'($signed(so_o)), e);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 valid in reset", int'(valid_o), 0);
    chk("R1 llr in reset", int'(llr_o), 0);
    chk("R1 so in reset", int'(so_o), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(valid_o), 0);
    chk("R1 llr after reset", int'(llr_o), 0);
  endtask

  task automatic t_scale;
    apply("R4 r0 0", 0, 0);
    apply("R4 r0 12", 0, 12);
    apply("R4 r0 25", 0, 25);
    apply("R4 r2 100", 2, 100);
    apply("R4 r1 300", 1, 300);
    apply("R4 r3 -500", 3, -500);
    chk("R4 r2 100 value", exp_llr(2, 100), 2);
  endtask

  task automatic t_ties;
    apply("R5 tie +2.5 r0", 0, 64);
    chk("R5 +2.5 rounds to 3", int'($signed(llr_o)), 3);
    apply("R5 tie -2.5 r0", 0, -64);
    chk("R5 -2.5 rounds to -3", int'($signed(llr_o)), -3);
    apply("R5 tie 7.5 r0", 0, 192);
    apply("R5 tie 7.5 r1", 1, 256);
    apply("R5 tie -7.5 r1", 1, -256);
    apply("R5 tie 2.5 r3", 3, 128);
  endtask

  task automatic t_clip;
    int thr [4] = '{384, 512, 632, 768};
    for (int r = 0; r < 4; r++) begin
      apply("R7 +thr", r, thr[r]);
      chk("R7 +thr is 15", int'($signed(llr_o)), 15);
      apply("R7 -thr", r, -thr[r]);
      chk("R7 -thr is -15", int'($signed(llr_o)), -15);
      apply("R3 above thr", r, thr[r] + 1);
      apply("R3 max pos", r, 2047);
      apply("R3 max neg", r, -2048);
      chk("R3 -8.0 not -16", int'($signed(llr_o)), -15);
    end
    apply("R3 just below thr r0", 0, 383);
  endtask

  task automatic t_sweep;
    for (int r = 0; r < 4; r++) begin
      for (int y = -2048; y < 2048; y += 61) begin
        apply("R4 sweep", r, y);
      end
    end
  endtask

  task automatic t_symmetry;
    int p;
    for (int y = 1; y < 900; y += 47) begin
      apply("R6 pos", 2, y);
      p = int'($signed(llr_o));
      apply("R6 neg", 2, -y);
      chk("R6 odd symmetry", int'($signed(llr_o)), -p);
    end
  endtask

  task automatic t_hold;
    apply("R8 setup", 1, -400);
    @(negedge clk);
    valid_i = 1'b0; rate_i = 2'd0; sample_i = 12'd300;
    @(negedge clk);
    chk("R8 valid low", int'(valid_o), 0);
    chk("R8 llr held", int'($signed(llr_o)), exp_llr(1, -400));
    chk("R8 so held", int'($signed(so_o)), exp_llr(1, -400));
    @(negedge clk);
    chk("R8 llr still held", int'($signed(llr_o)), exp_llr(1, -400));
  endtask

  task automatic t_stream;
    int ys [4] = '{100, -700, 256, -64};
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      valid_i = 1'b1; rate_i = 2'(3 - i); sample_i = 12'(ys[i]);
      @(negedge clk);
      chk("R2 stream valid", int'(valid_o), 1);
      chk("R2 stream llr", int'($signed(llr_o)), exp_llr(3 - i, ys[i]));
    end
    valid_i = 1'b0;
    @(negedge clk);
    chk("R2 valid drops", int'(valid_o), 0);
  endtask

  task automatic t_so_code;
    apply("R9 -15 pattern", 0, -1000);
    chk("R9 so bits", int'(so_o), 6'b110001);
  endtask

  initial begin
    t_reset();
    t_scale();
    t_ties();
    t_clip();
    t_symmetry();
    t_hold();
    t_stream();
    t_so_code();
    t_sweep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule